// File: doc/BRIEF.md
# Local Bus Access Timeout Watchdog

This block supervises every access on a local processor bus and reports a transfer error to the bus master when the addressed target does not return its normal acknowledge in time. Each access begins with a one-clock start strobe. From that clock on, the watchdog counts bus clocks. If the acknowledge has not arrived when the selected limit expires, it emits a single-clock transfer error acknowledge pulse. The master then terminates the access with a bus error.

Software controls the watchdog through a three-bit configuration word. That word holds an enable bit and a two-bit length select. Three select codes give finite limits of 8 µs, 64 µs and 256 µs. At the default 25 MHz bus clock these are 200, 1600 and 6400 clocks. The fourth code never times out. Accesses that are flagged at their start as going out to an external system bus are not timed here, because other logic supervises them. The clock rate, the three limits and the counter style (up-counting compare or down-counting load) are parameters.

Top module: `lbtw_timeout_wdog`

## Requirements
- R1: After reset the transfer error output is low and the configuration reads back as 3'b000 (disabled, select 00).
- R2: With the watchdog enabled, an access started with select 00, 01 or 10 and never acknowledged raises the error output exactly L clocks after the clock edge that sampled the start strobe. L is 200, 1600 or 6400 clocks respectively at the default parameters.
- R3: An access started while the select is 11 never raises the error, however long it stays open.
- R4: An access whose external-bus flag is high in the clock that samples its start strobe is not timed and never raises the error.
- R5: With the enable bit at 0, the error is never raised. Clearing the enable while an access is being timed abandons that access.
- R6: A normal acknowledge sampled before the limit closes the access, and no error follows.
- R7: If the normal acknowledge is sampled in the same clock in which the limit expires, the acknowledge wins and no error is raised.
- R8: The error pulse lasts exactly one clock. The watchdog then stays idle and raises nothing more until the next start strobe.
- R9: A start strobe during an access that is still open restarts the count from zero for the new access.
- R10: A configuration write stores cfg_wdata, with bit 0 as the enable and bits 2:1 as the select, and the stored value appears on cfg_rdata from the next clock.
- R11: The limit is captured with the start strobe, so a select change while an access is being timed does not alter that access's limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus access |
| ack_in | input | 1 | Normal acknowledge from the target |
| ext_bound | input | 1 | High with cyc_start when the access goes to the external system bus |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration word: bit 0 enable, bits 2:1 select |
| cfg_rdata | output | 3 | Stored configuration word |
| tea_out | output | 1 | One-clock transfer error acknowledge to the bus master |

## Verification
The properties assume that all inputs are synchronous to the bus clock. They also assume that ext_bound is meaningful only in the clock that carries cyc_start, and that acknowledge timing relative to the limit is arbitrary. The stimulus changes inputs only on the falling edge and holds each strobe for exactly one clock. It places the acknowledge before the limit and exactly on the limit edge. It also changes the configuration while an access is still open, so that the capture-at-start and abandon-on-disable rules are both exercised.

// File: rtl/lbtw_pkg.sv
package lbtw_pkg;

   typedef enum logic [1:0] {
      SEL_SHORT = 2'b00,
      SEL_MED   = 2'b01,
      SEL_LONG  = 2'b10,
      SEL_NEVER = 2'b11
   } tmo_sel_e;

   typedef enum logic {
      TMR_IDLE  = 1'b0,
      TMR_ARMED = 1'b1
   } tmr_state_e;

   // bit 0 enable, bits 2:1 select
   typedef struct packed {
      tmo_sel_e sel;
      logic     en;
   } cfg_t;

   localparam int unsigned CFG_W = $bits(cfg_t);

endpackage

// File: rtl/lbtw_cfg_reg.sv
module lbtw_cfg_reg
   import lbtw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '{sel: SEL_SHORT, en: 1'b0};
      end else if (wr) begin
         cfg <= cfg_t'(wdata);
      end
   end

endmodule

// File: rtl/lbtw_limit_sel.sv
module lbtw_limit_sel
   import lbtw_pkg::*;
#(
   parameter int unsigned CNT_W     = 13,
   parameter int unsigned LIM_SHORT = 200,
   parameter int unsigned LIM_MED   = 1600,
   parameter int unsigned LIM_LONG  = 6400
)(
   input  tmo_sel_e         sel,
   output logic [CNT_W-1:0] lim_m1,
   output logic             timed
);

   always_comb begin
      unique case (sel)
         SEL_SHORT: lim_m1 = CNT_W'(LIM_SHORT - 1);
         SEL_MED:   lim_m1 = CNT_W'(LIM_MED - 1);
         SEL_LONG:  lim_m1 = CNT_W'(LIM_LONG - 1);
         default:   lim_m1 = '0;
      endcase
      timed = (sel != SEL_NEVER);
   end

endmodule

// File: rtl/lbtw_cycle_timer.sv
module lbtw_cycle_timer
   import lbtw_pkg::*;
#(
   parameter int unsigned CNT_W      = 13,
   parameter bit          DOWN_COUNT = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ack,
   input  logic             ext,
   input  logic             en,
   input  logic             timed,
   input  logic [CNT_W-1:0] lim_m1,
   output logic             tea
);

   tmr_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             arm;

   assign arm = en && timed && !ext;

   generate
      if (DOWN_COUNT) begin : g_down
         // Counter loaded with limit-1, error when it reaches zero.
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               state_q <= TMR_IDLE;
               cnt_q   <= '0;
               tea     <= 1'b0;
            end else begin
               tea <= 1'b0;
               if (start) begin
                  state_q <= arm ? TMR_ARMED : TMR_IDLE;
                  cnt_q   <= lim_m1;
               end else if (state_q == TMR_ARMED) begin
                  if (!en || ack) begin
                     state_q <= TMR_IDLE;
                  end else if (cnt_q == '0) begin
                     tea     <= 1'b1;
                     state_q <= TMR_IDLE;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
            end
         end
      end else begin : g_up
         // Counter from zero, compared against the captured limit.
         logic [CNT_W-1:0] lim_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               state_q <= TMR_IDLE;
               cnt_q   <= '0;
               lim_q   <= '0;
               tea     <= 1'b0;
            end else begin
               tea <= 1'b0;
               if (start) begin
                  state_q <= arm ? TMR_ARMED : TMR_IDLE;
                  cnt_q   <= '0;
                  lim_q   <= lim_m1;
               end else if (state_q == TMR_ARMED) begin
                  if (!en || ack) begin
                     state_q <= TMR_IDLE;
                  end else if (cnt_q == lim_q) begin
                     tea     <= 1'b1;
                     state_q <= TMR_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lbtw_timeout_wdog.sv
module lbtw_timeout_wdog
   import lbtw_pkg::*;
#(
   parameter int unsigned CLK_MHZ    = 25,
   parameter int unsigned T_SHORT_US = 8,
   parameter int unsigned T_MED_US   = 64,
   parameter int unsigned T_LONG_US  = 256,
   parameter bit          DOWN_COUNT = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_start,
   input  logic       ack_in,
   input  logic       ext_bound,
   input  logic       cfg_wr,
   input  logic [2:0] cfg_wdata,
   output logic [2:0] cfg_rdata,
   output logic       tea_out
);

   localparam int unsigned LIM_SHORT = CLK_MHZ * T_SHORT_US;
   localparam int unsigned LIM_MED   = CLK_MHZ * T_MED_US;
   localparam int unsigned LIM_LONG  = CLK_MHZ * T_LONG_US;
   localparam int unsigned CNT_W     = $clog2(LIM_LONG + 1);

   generate
      if (CLK_MHZ == 0)
         $error("lbtw: CLK_MHZ must be nonzero");
      if (T_SHORT_US == 0 || T_SHORT_US >= T_MED_US || T_MED_US >= T_LONG_US)
         $error("lbtw: limits must be nonzero and strictly increasing");
      if (CFG_W != 3)
         $error("lbtw: configuration word must be 3 bits");
   endgenerate

   cfg_t             cfg;
   logic [CNT_W-1:0] lim_m1;
   logic             timed;

   lbtw_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   lbtw_limit_sel #(
      .CNT_W     (CNT_W),
      .LIM_SHORT (LIM_SHORT),
      .LIM_MED   (LIM_MED),
      .LIM_LONG  (LIM_LONG)
   ) u_lim (
      .sel    (cfg.sel),
      .lim_m1 (lim_m1),
      .timed  (timed)
   );

   lbtw_cycle_timer #(
      .CNT_W      (CNT_W),
      .DOWN_COUNT (DOWN_COUNT)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cyc_start),
      .ack    (ack_in),
      .ext    (ext_bound),
      .en     (cfg.en),
      .timed  (timed),
      .lim_m1 (lim_m1),
      .tea    (tea_out)
   );

   assign cfg_rdata = cfg;

endmodule

// File: rtl/lbtw_chk.sv
module lbtw_chk #(
   parameter int unsigned CLK_MHZ    = 25,
   parameter int unsigned T_SHORT_US = 8,
   parameter int unsigned T_MED_US   = 64,
   parameter int unsigned T_LONG_US  = 256
)(
   input logic       clk,
   input logic       rst_n,
   input logic       cyc_start,
   input logic       ack_in,
   input logic       ext_bound,
   input logic       cfg_wr,
   input logic [2:0] cfg_wdata,
   input logic [2:0] cfg_rdata,
   input logic       tea_out
);

   function automatic int unsigned lim_of(input logic [1:0] s);
      case (s)
         2'b00:   return CLK_MHZ * T_SHORT_US;
         2'b01:   return CLK_MHZ * T_MED_US;
         2'b10:   return CLK_MHZ * T_LONG_US;
         default: return 0;
      endcase
   endfunction

   int unsigned elapsed;
   int unsigned lim_at;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= 0;
         lim_at  <= 0;
      end else if (cyc_start) begin
         elapsed <= 0;
         lim_at  <= lim_of(cfg_rdata[2:1]);
      end else if (elapsed != 32'hFFFF_FFFF) begin
         elapsed <= elapsed + 1;
      end
   end

   AST_TEA_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      tea_out |-> (elapsed == lim_at)); // R2
   AST_NEVER_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && cfg_rdata[2:1] == 2'b11) |=> !tea_out); // R3
   AST_EXT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && ext_bound) |=> !tea_out); // R4
   AST_TEA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tea_out |-> $past(cfg_rdata[0])); // R5
   AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_in |=> !tea_out); // R7
   AST_TEA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tea_out |=> !tea_out); // R8
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> !tea_out); // R9
   AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_rdata == $past(cfg_wdata))); // R10

endmodule

bind lbtw_timeout_wdog lbtw_chk #(
   .CLK_MHZ    (CLK_MHZ),
   .T_SHORT_US (T_SHORT_US),
   .T_MED_US   (T_MED_US),
   .T_LONG_US  (T_LONG_US)
) u_chk (.*);

// File: tb/lbtw_timeout_wdog_tb.sv
module lbtw_timeout_wdog_tb;

   localparam int CLK_PERIOD = 40;
   localparam int LS = 200;
   localparam int LM = 1600;
   localparam int LL = 6400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0;
   logic       ack_in = 1'b0;
   logic       ext_bound = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_wdata = 3'b000;
   logic [2:0] cfg_rdata;
   logic       tea_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lbtw_timeout_wdog u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .ack_in    (ack_in),
      .ext_bound (ext_bound),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .tea_out   (tea_out)
   );

   // behavioural reference model
   bit         m_act;
   int         m_cnt;
   int         m_lim;
   bit         m_en;
   logic [1:0] m_sel;
   bit         m_tea;

   function automatic int lim_for(input logic [1:0] s);
      case (s)
         2'b00:   return LS;
         2'b01:   return LM;
         2'b10:   return LL;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_cnt = 0; m_lim = 0; m_en = 0; m_sel = 2'b00; m_tea = 0;
      end else begin
         m_tea = 0;
         if (cyc_start) begin
            m_act = m_en && !ext_bound && (m_sel != 2'b11);
            m_cnt = 0;
            m_lim = lim_for(m_sel);
         end else if (m_act) begin
            if (!m_en || ack_in) m_act = 0;
            else begin
               m_cnt++;
               if (m_cnt == m_lim) begin
                  m_tea = 1;
                  m_act = 0;
               end
            end
         end
         if (cfg_wr) begin
            m_en  = cfg_wdata[0];
            m_sel = cfg_wdata[2:1];
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (tea_out !== m_tea || cfg_rdata !== {m_sel, m_en}) begin
            n_fail++;
            $display("FAIL model R2 R6 R8 R11: tea=%0b cfg=%0b expected tea=%0b cfg=%0b",
                     tea_out, cfg_rdata, m_tea, {m_sel, m_en});
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [2:0] v);
      cfg_wdata = v; cfg_wr = 1'b1;
      cyc(1);
      cfg_wr = 1'b0;
   endtask

   task automatic start(input bit ext);
      cyc_start = 1'b1; ext_bound = ext;
      cyc(1);
      cyc_start = 1'b0; ext_bound = 1'b0;
   endtask

   // clocks from the start edge until tea is seen, capped
   task automatic measure(input int cap, output int n);
      n = 0;
      while (tea_out !== 1'b1 && n < cap) begin
         cyc(1);
         n++;
      end
   endtask

   // count tea pulses over a window
   task automatic quiet(input int len, output int hits);
      hits = 0;
      for (int i = 0; i < len; i++) begin
         cyc(1);
         if (tea_out === 1'b1) hits++;
      end
   endtask

   initial begin
      int n;
      int h;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk(tea_out === 1'b0, "R1 tea after reset", int'(tea_out), 0);
      chk(cfg_rdata === 3'b000, "R1 cfg after reset", int'(cfg_rdata), 0);

      wr_cfg(3'b101);
      chk(cfg_rdata === 3'b101, "R10 readback", int'(cfg_rdata), 5);
      wr_cfg(3'b001);
      chk(cfg_rdata === 3'b001, "R10 readback", int'(cfg_rdata), 1);

      start(1'b0);
      measure(LS + 20, n);
      chk(n == LS, "R2 select 00 delay", n, LS);
      cyc(1);
      chk(tea_out === 1'b0, "R8 pulse width", int'(tea_out), 0);
      quiet(300, h);
      chk(h == 0, "R8 idle after pulse", h, 0);

      wr_cfg(3'b011);
      start(1'b0);
      measure(LM + 20, n);
      chk(n == LM, "R2 select 01 delay", n, LM);
      wr_cfg(3'b101);
      start(1'b0);
      measure(LL + 20, n);
      chk(n == LL, "R2 select 10 delay", n, LL);

      wr_cfg(3'b001);
      start(1'b0);
      cyc(99);
      ack_in = 1'b1; cyc(1); ack_in = 1'b0;
      quiet(300, h);
      chk(h == 0, "R6 early ack", h, 0);

      start(1'b0);
      cyc(LS - 1);
      ack_in = 1'b1; cyc(1); ack_in = 1'b0;
      chk(tea_out === 1'b0, "R7 ack on limit edge", int'(tea_out), 0);
      quiet(300, h);
      chk(h == 0, "R7 no late error", h, 0);

      start(1'b0);
      cyc(149);
      start(1'b0);
      measure(LS + 20, n);
      chk(n == LS, "R9 restart delay", n, LS);

      wr_cfg(3'b111);
      start(1'b0);
      quiet(LL + 600, h);
      chk(h == 0, "R3 never code", h, 0);

      wr_cfg(3'b001);
      start(1'b1);
      quiet(400, h);
      chk(h == 0, "R4 external access", h, 0);

      wr_cfg(3'b000);
      start(1'b0);
      quiet(400, h);
      chk(h == 0, "R5 disabled", h, 0);
      wr_cfg(3'b001);
      start(1'b0);
      cyc(99);
      wr_cfg(3'b000);
      quiet(400, h);
      chk(h == 0, "R5 disabled mid access", h, 0);

      wr_cfg(3'b001);
      start(1'b0);
      cyc(49);
      wr_cfg(3'b101);
      n = 0;
      measure(LS, n);
      chk(n + 50 == LS, "R11 limit captured at start", n + 50, LS);

      cyc(5);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule